// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block is the front end of a synchronous, flow-through burst SRAM with a small storage array that can be sized by parameter. It samples every control and address input on the rising clock edge. From those samples it classifies the cycle as one of four kinds: deselect, burst start, burst advance or burst hold. It then performs a byte-masked write, or presents read data. Read data comes from the array for the address registered at the last edge, with no output register in between. A separate drive-enable output, gated without a clock by an active-low output enable, lets a pad ring build a tristate data bus.

Two start strobes begin a burst. The processor strobe needs only the primary enable to be asserted, and it always reads. The controller strobe checks all three enables and obeys the write controls. When neither strobe is active, the burst advances or holds and the enables are ignored. The two low address bits step through a four-beat burst, in linear or interleaved order, as the mode pin selects. The data bus takes one transfer per clock and has no back-pressure, so it carries no valid/ready handshake.

Top module: `sram_burst_ctrl`

## Requirements
- R1: While reset is asserted, and after it until a selecting start cycle, `dq_oe` is 0.
- R2: A controller start (`adsc_n`=0, processor start not taken) with `ce_n`=1, `ce2`=0 or `ce2_n`=1 deselects the block. It writes nothing, and `dq_oe` is 0 in the following cycle.
- R3: When `adsp_n`=0 and `ce_n`=0, a read burst begins at `addr` if `ce2`=1 and `ce2_n`=0, whatever the write inputs are. Otherwise the cycle deselects.
- R4: `adsp_n`=0 has no effect while `ce_n`=1. The cycle is then decoded as if `adsp_n` were 1.
- R5: A controller start with all enables asserted begins a burst at `addr`. It is a write or a read according to the write controls.
- R6: With no start taken, `adv_n`=0 moves to the next burst address and `adv_n`=1 keeps the current one. The chip enables are ignored. A deselected block stays deselected.
- R7: With `burst_interleave`=0, beat n of a burst uses low address bits (start + n) mod 4.
- R8: With `burst_interleave`=1, beat n uses low address bits start XOR n.
- R9: `gw_n`=0 writes all data bits, whatever `bwe_n` and `bw_n` are.
- R10: With `gw_n`=1 and `bwe_n`=0, a low `bw_n[0]` writes `dq_in[7:0]` and a low `bw_n[1]` writes `dq_in[15:8]`. If both strobes are 1, or if `bwe_n`=1, the cycle is a read.
- R11: `dq_oe` is 1 only during a read cycle of a selected burst while `oe_n`=0. It follows `oe_n` without waiting for a clock edge.
- R12: Read data for the address registered at an edge is valid on `dq_out` within the same clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_interleave | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr | input | ADDR_W | Word address; the two low bits seed the burst |
| ce_n | input | 1 | Primary chip enable, active low |
| ce2 | input | 1 | Secondary chip enable, active high |
| ce2_n | input | 1 | Secondary chip enable, active low |
| adsp_n | input | 1 | Processor burst start, read only |
| adsc_n | input | 1 | Controller burst start |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, all bytes |
| bwe_n | input | 1 | Byte write enable |
| bw_n | input | NBYTE | Per-byte write strobes, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_in | input | BYTE_W*NBYTE | Write data |
| dq_out | output | BYTE_W*NBYTE | Read data |
| dq_oe | output | 1 | Bus drive enable for dq_out |

## Verification
The bench builds the block with its defaults: a 6-bit address, two 8-bit lanes and a 2-bit burst counter. That gives 64 words, so a few words in one four-word burst group show every wrap of both burst orders. The 16-bit data makes each single-lane write show up as a partly changed word. Because the burst order is a pin, linear and interleaved bursts run in the same build, one after the other, on data written earlier in the run.

// File: rtl/sram_burst_pkg.sv
package sram_burst_pkg;
  typedef enum logic [1:0] {
    CYC_DESEL = 2'd0,
    CYC_START = 2'd1,
    CYC_CONT  = 2'd2,
    CYC_HOLD  = 2'd3
  } cyc_kind_e;
endpackage

// File: rtl/sram_cycle_decode.sv
module sram_cycle_decode
  import sram_burst_pkg::*;
#(
  parameter int NBYTE = 2
) (
  input  logic             ce_n,
  input  logic             ce2,
  input  logic             ce2_n,
  input  logic             adsp_n,
  input  logic             adsc_n,
  input  logic             adv_n,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [NBYTE-1:0] bw_n,
  output cyc_kind_e        kind,
  output logic             wr_en,
  output logic [NBYTE-1:0] lane_mask
);
  logic selected;
  logic proc_start;

  assign selected   = !ce_n && ce2 && !ce2_n;
  // processor strobe is only honoured while the primary enable is low
  assign proc_start = !adsp_n && !ce_n;

  always_comb begin
    if (proc_start)   kind = selected ? CYC_START : CYC_DESEL;
    else if (!adsc_n) kind = selected ? CYC_START : CYC_DESEL;
    else if (!adv_n)  kind = CYC_CONT;
    else              kind = CYC_HOLD;
  end

  always_comb begin
    if (!gw_n)       lane_mask = '1;
    else if (!bwe_n) lane_mask = ~bw_n;
    else             lane_mask = '0;
  end

  assign wr_en = !proc_start && (lane_mask != '0);
endmodule

// File: rtl/sram_burst_seq.sv
module sram_burst_seq #(
  parameter int BURST_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               step,
  input  logic [BURST_W-1:0] start_lo,
  input  logic               interleave,
  output logic [BURST_W-1:0] cur_lo,
  output logic [BURST_W-1:0] nxt_lo
);
  logic [BURST_W-1:0] base_q;
  logic [BURST_W-1:0] beat_q;
  logic [BURST_W-1:0] beat_nx;

  function automatic logic [BURST_W-1:0] beat_addr(
    input logic [BURST_W-1:0] s,
    input logic [BURST_W-1:0] n,
    input logic               il
  );
    return il ? (s ^ n) : (s + n);
  endfunction

  assign beat_nx = beat_q + 1'b1;
  assign cur_lo  = beat_addr(base_q, beat_q, interleave);
  assign nxt_lo  = beat_addr(base_q, beat_nx, interleave);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
    end else if (load) begin
      base_q <= start_lo;
      beat_q <= '0;
    end else if (step) begin
      beat_q <= beat_nx;
    end
  end
endmodule

// File: rtl/sram_byte_array.sv
module sram_byte_array #(
  parameter int ADDR_W = 6,
  parameter int BYTE_W = 8,
  parameter int NBYTE  = 2
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [NBYTE-1:0]        lane_mask,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [BYTE_W*NBYTE-1:0] wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [BYTE_W*NBYTE-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar b = 0; b < NBYTE; b++) begin : g_lane
    logic [BYTE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (we && lane_mask[b]) cells[wr_addr] <= wr_data[b*BYTE_W +: BYTE_W];
    end

    assign rd_data[b*BYTE_W +: BYTE_W] = cells[rd_addr];
  end
endmodule

// File: rtl/sram_burst_ctrl.sv
module sram_burst_ctrl
  import sram_burst_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int BYTE_W  = 8,
  parameter int NBYTE   = 2,
  parameter int BURST_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    burst_interleave,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    ce_n,
  input  logic                    ce2,
  input  logic                    ce2_n,
  input  logic                    adsp_n,
  input  logic                    adsc_n,
  input  logic                    adv_n,
  input  logic                    gw_n,
  input  logic                    bwe_n,
  input  logic [NBYTE-1:0]        bw_n,
  input  logic                    oe_n,
  input  logic [BYTE_W*NBYTE-1:0] dq_in,
  output logic [BYTE_W*NBYTE-1:0] dq_out,
  output logic                    dq_oe
);
  localparam int UP_W = ADDR_W - BURST_W;

  cyc_kind_e          kind;
  logic               wr_en;
  logic [NBYTE-1:0]   lane_mask;
  logic               active_q;
  logic               cyc_wr_q;
  logic [UP_W-1:0]    up_q;
  logic [BURST_W-1:0] cur_lo;
  logic [BURST_W-1:0] nxt_lo;
  logic               load;
  logic               step;
  logic               mem_we;
  logic [ADDR_W-1:0]  wr_addr;

  sram_cycle_decode #(.NBYTE(NBYTE)) u_dec (
    .ce_n(ce_n), .ce2(ce2), .ce2_n(ce2_n),
    .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
    .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n),
    .kind(kind), .wr_en(wr_en), .lane_mask(lane_mask)
  );

  assign load = (kind == CYC_START);
  assign step = (kind == CYC_CONT) && active_q;

  sram_burst_seq #(.BURST_W(BURST_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step),
    .start_lo(addr[BURST_W-1:0]), .interleave(burst_interleave),
    .cur_lo(cur_lo), .nxt_lo(nxt_lo)
  );

  always_comb begin
    case (kind)
      CYC_START: wr_addr = addr;
      CYC_CONT:  wr_addr = {up_q, nxt_lo};
      default:   wr_addr = {up_q, cur_lo};
    endcase
  end

  // continuing cycles only write when a selected burst is open
  assign mem_we = wr_en && (load || (active_q && kind != CYC_DESEL));

  sram_byte_array #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NBYTE(NBYTE)) u_mem (
    .clk(clk), .we(mem_we), .lane_mask(lane_mask),
    .wr_addr(wr_addr), .wr_data(dq_in),
    .rd_addr({up_q, cur_lo}), .rd_data(dq_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cyc_wr_q <= 1'b0;
      up_q     <= '0;
    end else begin
      case (kind)
        CYC_START: begin
          active_q <= 1'b1;
          cyc_wr_q <= wr_en;
          up_q     <= addr[ADDR_W-1:BURST_W];
        end
        CYC_DESEL: begin
          active_q <= 1'b0;
          cyc_wr_q <= 1'b0;
        end
        default: begin
          if (active_q) cyc_wr_q <= wr_en;
        end
      endcase
    end
  end

  assign dq_oe = active_q && !cyc_wr_q && !oe_n;
endmodule

// File: rtl/sram_burst_ctrl_chk.sv
module sram_burst_ctrl_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              ce2,
  input logic              ce2_n,
  input logic              adsp_n,
  input logic              adsc_n,
  input logic              adv_n,
  input logic              gw_n,
  input logic              bwe_n,
  input logic              oe_n,
  input logic [DATA_W-1:0] dq_out,
  input logic              dq_oe
);
  AST_OE_GATES_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !oe_n); // R11

  AST_CTRL_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    ((adsp_n || ce_n) && !adsc_n && (ce_n || !ce2 || ce2_n)) |=> !dq_oe); // R2

  AST_PROC_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (!adsp_n && !ce_n && (!ce2 || ce2_n)) |=> !dq_oe); // R3

  AST_PROC_READS: assert property (@(posedge clk) disable iff (!rst_n)
    (!adsp_n && !ce_n && ce2 && !ce2_n) |=> (dq_oe || oe_n)); // R3

  AST_GLOBAL_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((adsp_n || ce_n) && !gw_n) |=> !dq_oe); // R9

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((adsp_n || ce_n) && adsc_n && adv_n && gw_n && bwe_n) |=> $stable(dq_out)); // R6
endmodule

bind sram_burst_ctrl sram_burst_ctrl_chk #(.DATA_W(BYTE_W*NBYTE)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .ce2(ce2), .ce2_n(ce2_n),
  .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n), .gw_n(gw_n),
  .bwe_n(bwe_n), .oe_n(oe_n), .dq_out(dq_out), .dq_oe(dq_oe)
);

// File: tb/tb_sram_burst_ctrl.sv
`timescale 1ns/1ps
module tb_sram_burst_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        burst_interleave = 1'b0;
  logic [5:0]  addr = '0;
  logic        ce_n = 1'b0, ce2 = 1'b1, ce2_n = 1'b0;
  logic        adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1;
  logic        gw_n = 1'b1, bwe_n = 1'b1;
  logic [1:0]  bw_n = 2'b11;
  logic        oe_n = 1'b1;
  logic [15:0] dq_in = '0;
  logic [15:0] dq_out;
  logic        dq_oe;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sram_burst_ctrl dut (
    .clk(clk), .rst_n(rst_n), .burst_interleave(burst_interleave), .addr(addr),
    .ce_n(ce_n), .ce2(ce2), .ce2_n(ce2_n), .adsp_n(adsp_n), .adsc_n(adsc_n),
    .adv_n(adv_n), .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  typedef struct packed {
    logic        ce_n, ce2, ce2_n, adsp_n, adsc_n, adv_n, gw_n, bwe_n;
    logic [1:0]  bw_n;
    logic        oe_n, mode;
    logic [5:0]  addr;
    logic [15:0] din;
    logic        drv;
    logic [15:0] q;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{0,1,0, 1,0,1, 0,1,2'b11, 1,0, 6'h08,16'h1111, 0,16'h0000, 9}, // R9 R5 start write
    '{0,1,0, 1,1,0, 0,1,2'b11, 1,0, 6'h00,16'h2222, 0,16'h0000, 9}, // R9 advance write
    '{0,1,0, 1,1,0, 0,1,2'b11, 1,0, 6'h00,16'h3333, 0,16'h0000, 9},
    '{0,1,0, 1,1,0, 0,1,2'b11, 1,0, 6'h00,16'h4444, 0,16'h0000, 9},
    '{0,1,0, 0,1,1, 0,1,2'b11, 0,0, 6'h0A,16'hDEAD, 1,16'h3333, 3}, // R3 forced read
    '{0,1,0, 1,1,0, 1,1,2'b11, 0,0, 6'h00,16'h0000, 1,16'h4444, 7}, // R7
    '{0,1,0, 1,1,0, 1,1,2'b11, 0,0, 6'h00,16'h0000, 1,16'h1111, 7}, // R7 wrap
    '{0,1,0, 1,1,1, 1,1,2'b11, 0,0, 6'h00,16'h0000, 1,16'h1111, 6}, // R6 hold
    '{0,1,0, 1,1,0, 1,1,2'b11, 0,0, 6'h00,16'h0000, 1,16'h2222, 7}, // R7
    '{0,1,0, 0,1,1, 1,1,2'b11, 0,1, 6'h09,16'h0000, 1,16'h2222, 8}, // R8
    '{0,1,0, 1,1,0, 1,1,2'b11, 0,1, 6'h00,16'h0000, 1,16'h1111, 8},
    '{0,1,0, 1,1,0, 1,1,2'b11, 0,1, 6'h00,16'h0000, 1,16'h4444, 8},
    '{0,1,0, 1,1,0, 1,1,2'b11, 0,1, 6'h00,16'h0000, 1,16'h3333, 8}, // R8 and R3 no write
    '{0,1,0, 1,0,1, 1,0,2'b10, 1,0, 6'h08,16'hABCD, 0,16'h0000, 10}, // R10 low lane
    '{0,1,0, 1,1,1, 1,0,2'b01, 1,0, 6'h00,16'hEF00, 0,16'h0000, 10}, // R10 high lane
    '{0,1,0, 1,1,1, 1,0,2'b11, 0,0, 6'h00,16'h5555, 1,16'hEFCD, 10}, // R10 both high reads
    '{0,1,0, 1,1,1, 1,0,2'b11, 1,0, 6'h00,16'h5555, 0,16'h0000, 11}, // R11 oe high
    '{0,1,0, 1,0,1, 1,1,2'b00, 0,0, 6'h0B,16'h7777, 1,16'h4444, 10}, // R10 bwe high reads
    '{1,1,0, 1,0,1, 0,1,2'b11, 0,0, 6'h0B,16'h9999, 0,16'h0000, 2},  // R2
    '{0,1,0, 1,1,0, 1,1,2'b11, 0,0, 6'h00,16'h0000, 0,16'h0000, 6},  // R6 stays deselected
    '{0,0,0, 0,1,1, 1,1,2'b11, 0,0, 6'h08,16'h0000, 0,16'h0000, 3},  // R3 ce2 low
    '{0,1,1, 0,1,1, 1,1,2'b11, 0,0, 6'h08,16'h0000, 0,16'h0000, 3},  // R3 ce2_n high
    '{0,1,0, 1,0,1, 1,1,2'b11, 0,0, 6'h0B,16'h0000, 1,16'h4444, 5},  // R5 R2 nothing written
    '{1,1,0, 0,1,1, 1,1,2'b11, 0,0, 6'h00,16'h0000, 1,16'h4444, 4},  // R4 adsp ignored
    '{1,0,1, 1,1,0, 1,1,2'b11, 0,0, 6'h00,16'h0000, 1,16'hEFCD, 6}   // R6 enables ignored, R12
  };

  task automatic check_bus(input bit exp_drv, input logic [15:0] exp_q, input int req);
    checks++;
    if (dq_oe !== exp_drv || (exp_drv && dq_out !== exp_q)) begin
      errors++;
      $display("FAIL R%0d: dq_oe=%0b dq_out=%h expected dq_oe=%0b dq_out=%h",
               req, dq_oe, dq_out, exp_drv, exp_q);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    oe_n = 1'b0;
    #0.5 check_bus(0, 16'h0, 1); // R1 during reset
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check_bus(0, 16'h0, 1); // R1 idle after reset

    for (int i = 0; i < NV; i++) begin
      ce_n = VECS[i].ce_n; ce2 = VECS[i].ce2; ce2_n = VECS[i].ce2_n;
      adsp_n = VECS[i].adsp_n; adsc_n = VECS[i].adsc_n; adv_n = VECS[i].adv_n;
      gw_n = VECS[i].gw_n; bwe_n = VECS[i].bwe_n; bw_n = VECS[i].bw_n;
      oe_n = VECS[i].oe_n; burst_interleave = VECS[i].mode;
      addr = VECS[i].addr; dq_in = VECS[i].din;
      @(posedge clk); @(negedge clk);
      check_bus(VECS[i].drv, VECS[i].q, int'(VECS[i].req));
    end

    // R11: output enable acts without a clock edge
    ce_n = 1'b0; ce2 = 1'b1; ce2_n = 1'b0; adsp_n = 1'b1; adsc_n = 1'b1;
    adv_n = 1'b1; gw_n = 1'b1; bwe_n = 1'b1; bw_n = 2'b11; oe_n = 1'b0;
    @(posedge clk); @(negedge clk);
    check_bus(1, 16'hEFCD, 11);
    oe_n = 1'b1;
    #0.5 check_bus(0, 16'h0, 11);
    oe_n = 1'b0;
    #0.5 check_bus(1, 16'hEFCD, 11);

    // R1: reset in the middle of a read burst releases the bus
    @(negedge clk);
    rst_n = 1'b0;
    #0.5 check_bus(0, 16'h0, 1);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check_bus(0, 16'h0, 1); // hold cycles do not reopen a burst

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule